// File: doc/BRIEF.md
# Double-Buffered Sound Sample Fetcher

This block walks a sample buffer in DRAM for an eight-channel sound output. Each sound request makes it issue one group of eight byte addresses, one per channel, on eight consecutive cycles. After each group the live read pointer moves forward by eight bytes. When the pointer reaches or passes the live end address, the buffer is exhausted and the block raises a level interrupt.

Software programs a start and an end value through a small register-write port. Both are held apart from the live pointer and the live end address, so the next buffer can be queued while the current one plays. When a buffer runs out with sound enabled, the live pair reloads from the programmed pair and playback continues with no gap. When a buffer runs out with sound disabled, the block instead pulses a clear-channels output. A separate command register loads the live pair immediately and raises the interrupt. Writing a new start value clears the interrupt.

The DRAM reads and the output converter sit outside this block. A companion block consumes `fetch_addr` and `fetch_chan` on every cycle in which `fetch_valid` is high.

Top module: `snd_dma_engine`

## Requirements
- R1: Reset state. After reset, `fetch_valid`, `snd_irq` and `chan_clear` are low, sound is disabled, and every pointer is zero.
- R2: Register port.
  - A write takes effect on the clock edge at which `reg_we` is high.
  - `reg_sel` selects the target: 4 is the programmed start, 5 is the programmed end, 6 is the pointer command, 7 is the control register.
  - A control write sets the sound-enable flag to `ctl_snd_en`.
  - A start or end value V stands for byte address V×16.
- R3: Burst shape.
  - A request is the `snd_req` level sampled at a clock edge while sound is enabled and no burst is running.
  - It produces `fetch_valid` high for exactly the 8 cycles that follow that edge.
  - On beat k, `fetch_chan` is k (k = 0..7) and `fetch_addr` is the live pointer plus k.
- R4: After the last beat of a burst, the live pointer is 8 higher than it was during the burst.
- R5: A request is ignored while sound is disabled or while a burst is running. An ignored request produces no `fetch_valid`.
- R6: A pointer-command write loads the live pointer from the programmed start and the live end from the programmed end. It also sets `snd_irq`.
- R7: A control write with `ctl_snd_en` = 1 reloads the live pointer and live end in the same way as R6, even if sound is already enabled.
- R8: If the advanced pointer is greater than or equal to the live end, `snd_irq` is high from the cycle after the last beat.
- R9: If R8 occurs while sound is enabled, the live pointer and live end reload from the programmed pair as it stands at that edge. The next burst therefore starts at the programmed start.
- R10: If R8 occurs while sound is disabled, `chan_clear` is high for exactly one cycle, the cycle after the last beat.
- R11: `snd_irq` is a level that only a start write clears. If a start write coincides with an exhaustion, the set wins.
- R12: A start or end write does not touch the live pointer or live end until the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index (4 start, 5 end, 6 pointer command, 7 control) |
| reg_val | input | PTR_W | Pointer value in 16-byte units |
| ctl_snd_en | input | 1 | Sound-enable bit carried by a control write |
| snd_req | input | 1 | Sound request strobe |
| fetch_valid | output | 1 | A fetch address is presented this cycle |
| fetch_chan | output | 3 | Channel index of the current beat |
| fetch_addr | output | PTR_W+4 | Byte address of the current beat |
| snd_irq | output | 1 | Sound interrupt, level |
| chan_clear | output | 1 | One-cycle pulse clearing all channel outputs |

## Verification
The hardest cases to reach are those where a register write lands on the same clock edge as a buffer exhaustion. Two such cases matter: a start write racing the interrupt set, and a control write that disables sound while a burst is still running. The bench handles both by firing the write from inside the burst task at a chosen beat, timed from the observed `fetch_chan` value. For the race, the write lands on the last beat. For the disable, it lands on beat 2 of a burst that will exhaust its buffer. Separately, a sweep over buffer lengths of 0 to 4 units, at a low and a near-top start address, counts the bursts up to the exhaustion predicted by arithmetic. It then checks that playback wraps back to the start.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;

  // Register indices decoded by the sound fetcher
  localparam logic [2:0] SEL_SND_START = 3'd4;
  localparam logic [2:0] SEL_SND_END   = 3'd5;
  localparam logic [2:0] SEL_SND_PTR   = 3'd6;
  localparam logic [2:0] SEL_CTRL      = 3'd7;

  // Pointer values are in 16-byte units
  localparam int UNIT_SHIFT = 4;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_BURST = 1'b1
  } seq_state_e;

endpackage

// File: rtl/snd_dma_regs.sv
module snd_dma_regs
  import snd_dma_pkg::*;
#(
  parameter int PTR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [PTR_W-1:0] reg_val,
  input  logic             ctl_snd_en,
  output logic [PTR_W-1:0] start_q,
  output logic [PTR_W-1:0] end_q,
  output logic             en_q,
  output logic             start_wr,
  output logic             ptr_cmd,
  output logic             reload
);

  logic             end_wr;
  logic             ctl_wr;
  logic [PTR_W-1:0] start_d;
  logic [PTR_W-1:0] end_d;
  logic             en_d;

  // Write decode
  always_comb begin
    start_wr = reg_we && (reg_sel == SEL_SND_START);
    end_wr   = reg_we && (reg_sel == SEL_SND_END);
    ptr_cmd  = reg_we && (reg_sel == SEL_SND_PTR);
    ctl_wr   = reg_we && (reg_sel == SEL_CTRL);
    reload   = ptr_cmd || (ctl_wr && ctl_snd_en);
  end

  // Next state
  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    en_d    = en_q;
    if (start_wr) start_d = reg_val;
    if (end_wr)   end_d   = reg_val;
    if (ctl_wr)   en_d    = ctl_snd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      en_q    <= 1'b0;
    end else begin
      if (start_wr) start_q <= start_d;
      if (end_wr)   end_q   <= end_d;
      if (ctl_wr)   en_q    <= en_d;
    end
  end

endmodule

// File: rtl/snd_dma_ptr.sv
module snd_dma_ptr
  import snd_dma_pkg::*;
#(
  parameter int PTR_W = 15,
  parameter int STEP  = 8,
  localparam int ADDR_W = PTR_W + UNIT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              step,
  input  logic              en,
  input  logic [PTR_W-1:0]  start_q,
  input  logic [PTR_W-1:0]  end_q,
  output logic [ADDR_W-1:0] cur_q,
  output logic              exhaust
);

  logic [ADDR_W-1:0] aend_q;
  logic [ADDR_W-1:0] cur_d;
  logic [ADDR_W-1:0] aend_d;
  logic [ADDR_W-1:0] start_b;
  logic [ADDR_W-1:0] end_b;
  logic [ADDR_W:0]   sum;
  logic              reached;
  logic              upd;

  always_comb begin
    start_b = {start_q, {UNIT_SHIFT{1'b0}}};
    end_b   = {end_q, {UNIT_SHIFT{1'b0}}};
    // One extra bit so that running off the top still counts as reaching the end
    sum     = {1'b0, cur_q} + (ADDR_W+1)'(STEP);
    reached = sum >= {1'b0, aend_q};
  end

  // Next state: a register-driven reload wins over the burst advance
  always_comb begin
    cur_d   = cur_q;
    aend_d  = aend_q;
    exhaust = 1'b0;
    if (reload) begin
      cur_d  = start_b;
      aend_d = end_b;
    end else if (step) begin
      exhaust = reached;
      if (reached && en) begin
        cur_d  = start_b;
        aend_d = end_b;
      end else begin
        cur_d = sum[ADDR_W-1:0];
      end
    end
  end

  assign upd = reload || step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      aend_q <= '0;
    end else if (upd) begin
      cur_q  <= cur_d;
      aend_q <= aend_d;
    end
  end

endmodule

// File: rtl/snd_dma_seq.sv
module snd_dma_seq
  import snd_dma_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int ADDR_W   = 19,
  localparam int BEAT_W  = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              en,
  input  logic [ADDR_W-1:0] cur,
  output logic              fetch_valid,
  output logic [BEAT_W-1:0] fetch_chan,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              last
);

  seq_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              launch;
  logic              busy;

  always_comb begin
    busy   = (state_q == SEQ_BURST);
    launch = (state_q == SEQ_IDLE) && req && en;
    last   = busy && (beat_q == BEAT_W'(CHANNELS - 1));
  end

  // Next state
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    if (launch) begin
      state_d = SEQ_BURST;
      beat_d  = '0;
    end else if (busy) begin
      if (last) begin
        state_d = SEQ_IDLE;
        beat_d  = '0;
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      beat_q  <= '0;
    end else if (launch || busy) begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  always_comb begin
    fetch_valid = busy;
    fetch_chan  = beat_q;
    fetch_addr  = cur + ADDR_W'(beat_q);
  end

endmodule

// File: rtl/snd_dma_irq.sv
module snd_dma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic exhaust,
  input  logic ptr_cmd,
  input  logic start_wr,
  input  logic en,
  output logic irq_q,
  output logic clr_q
);

  logic irq_d;
  logic clr_d;
  logic irq_upd;

  // Next state: setting has priority over clearing
  always_comb begin
    irq_upd = exhaust || ptr_cmd || start_wr;
    if (exhaust || ptr_cmd) irq_d = 1'b1;
    else                    irq_d = 1'b0;
    clr_d = exhaust && !en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      if (irq_upd) irq_q <= irq_d;
      clr_q <= clr_d;
    end
  end

endmodule

// File: rtl/snd_dma_engine.sv
module snd_dma_engine
  import snd_dma_pkg::*;
#(
  parameter int PTR_W    = 15,
  parameter int CHANNELS = 8,
  localparam int BEAT_W  = $clog2(CHANNELS),
  localparam int ADDR_W  = PTR_W + UNIT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [PTR_W-1:0]  reg_val,
  input  logic              ctl_snd_en,
  input  logic              snd_req,
  output logic              fetch_valid,
  output logic [BEAT_W-1:0] fetch_chan,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              snd_irq,
  output logic              chan_clear
);

  // Asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PTR_W-1:0]  start_q;
  logic [PTR_W-1:0]  end_q;
  logic              en_q;
  logic              start_wr;
  logic              ptr_cmd;
  logic              reload;
  logic [ADDR_W-1:0] cur_q;
  logic              exhaust;
  logic              last;

  snd_dma_regs #(.PTR_W(PTR_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_val   (reg_val),
    .ctl_snd_en(ctl_snd_en),
    .start_q   (start_q),
    .end_q     (end_q),
    .en_q      (en_q),
    .start_wr  (start_wr),
    .ptr_cmd   (ptr_cmd),
    .reload    (reload)
  );

  snd_dma_ptr #(.PTR_W(PTR_W), .STEP(CHANNELS)) i_ptr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .reload (reload),
    .step   (last),
    .en     (en_q),
    .start_q(start_q),
    .end_q  (end_q),
    .cur_q  (cur_q),
    .exhaust(exhaust)
  );

  snd_dma_seq #(.CHANNELS(CHANNELS), .ADDR_W(ADDR_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req        (snd_req),
    .en         (en_q),
    .cur        (cur_q),
    .fetch_valid(fetch_valid),
    .fetch_chan (fetch_chan),
    .fetch_addr (fetch_addr),
    .last       (last)
  );

  snd_dma_irq i_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .exhaust (exhaust),
    .ptr_cmd (ptr_cmd),
    .start_wr(start_wr),
    .en      (en_q),
    .irq_q   (snd_irq),
    .clr_q   (chan_clear)
  );

endmodule

// File: rtl/snd_dma_engine_chk.sv
module snd_dma_engine_chk #(
  parameter int PTR_W    = 15,
  parameter int CHANNELS = 8,
  localparam int BEAT_W  = $clog2(CHANNELS),
  localparam int ADDR_W  = PTR_W + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_sel,
  input logic              snd_req,
  input logic              fetch_valid,
  input logic [BEAT_W-1:0] fetch_chan,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              snd_irq,
  input logic              chan_clear
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(CHANNELS - 1);

  logic live_write;
  assign live_write = reg_we && (reg_sel == 3'd6 || reg_sel == 3'd7);

  // R3: a burst always opens on channel 0
  assert_burst_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_valid) |-> (fetch_chan == '0));

  // R3: beats follow one another without gaps
  assert_beat_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_chan != LAST_BEAT) |=>
      (fetch_valid && fetch_chan == BEAT_W'($past(fetch_chan) + 1'b1)));

  // R3: consecutive byte addresses unless a reload intervenes
  assert_addr_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_chan != LAST_BEAT && !live_write) |=>
      (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)));

  // R3: the burst closes after the last channel
  assert_burst_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_chan == LAST_BEAT) |=> !fetch_valid);

  // R5: a burst only starts after a request
  assert_burst_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_valid) |-> $past(snd_req));

  // R10: the clear pulse lasts one cycle
  assert_clear_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clear |=> !chan_clear);

  // R8: the clear pulse comes with an exhaustion, so the interrupt is up too
  assert_clear_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clear |-> snd_irq);

  // R11: only a start write lowers the interrupt
  assert_irq_falls_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snd_irq) |-> $past(reg_we && reg_sel == 3'd4));

endmodule

bind snd_dma_engine snd_dma_engine_chk #(.PTR_W(PTR_W), .CHANNELS(CHANNELS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_sel    (reg_sel),
  .snd_req    (snd_req),
  .fetch_valid(fetch_valid),
  .fetch_chan (fetch_chan),
  .fetch_addr (fetch_addr),
  .snd_irq    (snd_irq),
  .chan_clear (chan_clear)
);

// File: tb/test_snd_dma_engine.sv
module test_snd_dma_engine;

  localparam int CLK_PERIOD = 10;
  localparam int PTR_W      = 15;
  localparam int ADDR_W     = PTR_W + 4;

  logic              clk;
  logic              rst_n;
  logic              reg_we;
  logic [2:0]        reg_sel;
  logic [PTR_W-1:0]  reg_val;
  logic              ctl_snd_en;
  logic              snd_req;
  logic              fetch_valid;
  logic [2:0]        fetch_chan;
  logic [ADDR_W-1:0] fetch_addr;
  logic              snd_irq;
  logic              chan_clear;

  int vectors;
  int miscompares;

  snd_dma_engine #(.PTR_W(PTR_W), .CHANNELS(8)) i_snd_dma_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_val    (reg_val),
    .ctl_snd_en (ctl_snd_en),
    .snd_req    (snd_req),
    .fetch_valid(fetch_valid),
    .fetch_chan (fetch_chan),
    .fetch_addr (fetch_addr),
    .snd_irq    (snd_irq),
    .chan_clear (chan_clear)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input int val, input logic en);
    reg_we     = 1'b1;
    reg_sel    = sel;
    reg_val    = PTR_W'(val);
    ctl_snd_en = en;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // act: 0 none, 1 start write on the last beat, 2 disable on beat 2, 3 extra request on beat 3
  task automatic burst(input string req, input longint base, input int act, input int aval);
    snd_req = 1'b1;
    @(negedge clk);
    snd_req = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check({req, " valid"}, fetch_valid, 1);
      check({req, " chan"}, fetch_chan, k);
      check({req, " addr"}, fetch_addr, (base + k) % (1 << ADDR_W));
      if (act == 1 && k == 7) begin reg_we = 1; reg_sel = 3'd4; reg_val = PTR_W'(aval); end
      if (act == 2 && k == 2) begin reg_we = 1; reg_sel = 3'd7; ctl_snd_en = 0; end
      if (act == 3 && k == 3) snd_req = 1'b1;
      @(negedge clk);
      reg_we  = 1'b0;
      snd_req = 1'b0;
    end
    check({req, " end of burst"}, fetch_valid, 0);
  endtask

  task automatic idle_check(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      check(req, fetch_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    vectors = 0; miscompares = 0;
    reg_we = 0; reg_sel = 0; reg_val = 0; ctl_snd_en = 0; snd_req = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 fetch_valid", fetch_valid, 0);
    check("R1 snd_irq", snd_irq, 0);
    check("R1 chan_clear", chan_clear, 0);

    // R5 requests ignored while disabled
    snd_req = 1'b1;
    idle_check("R5 disabled request", 6);
    snd_req = 1'b0;

    // R1/R7 enable reloads zero pointers, first burst at 0; 8 >= 0 exhausts (R8, R9)
    wr(3'd7, 0, 1'b1);
    burst("R1 first burst", 0, 0, 0);
    check("R8 irq after zero buffer", snd_irq, 1);
    check("R10 no clear while enabled", chan_clear, 0);
    burst("R9 wrap to start", 0, 0, 0);

    // Sweep of buffer lengths and start addresses (R2, R4, R6, R8, R9, R11)
    for (int si = 0; si < 2; si++) begin
      for (int len = 0; len <= 4; len++) begin
        int s;
        int nexp;
        s = (si == 0) ? 3 : 'h7FF0;
        nexp = (len == 0) ? 1 : 2 * len;
        wr(3'd4, s, 1'b1);
        wr(3'd5, s + len, 1'b1);
        wr(3'd6, 0, 1'b1);
        check("R6 pointer command sets irq", snd_irq, 1);
        wr(3'd4, s, 1'b1);
        check("R11 start write clears irq", snd_irq, 0);
        for (int n = 1; n <= nexp; n++) begin
          burst("R4 sweep burst", longint'(s) * 16 + 8 * (n - 1), 0, 0);
          check("R8 irq at exhaustion", snd_irq, (n == nexp) ? 1 : 0);
        end
        burst("R9 sweep wrap", longint'(s) * 16, 0, 0);
      end
    end

    // R12 queued values do not disturb the live buffer
    wr(3'd4, 20, 1'b1);
    wr(3'd5, 22, 1'b1);
    wr(3'd6, 0, 1'b1);
    wr(3'd4, 20, 1'b1);
    burst("R12 live first", 320, 0, 0);
    wr(3'd4, 100, 1'b1);
    wr(3'd5, 200, 1'b1);
    check("R12 start write leaves irq low", snd_irq, 0);
    burst("R12 live second", 328, 0, 0);
    burst("R12 live third", 336, 0, 0);
    check("R12 no early exhaustion", snd_irq, 0);
    burst("R12 live fourth", 344, 0, 0);
    check("R8 irq after queued swap", snd_irq, 1);
    burst("R9 reload takes queued start", 1600, 0, 0);
    wr(3'd4, 100, 1'b1);

    // R7 control write with enable set reloads while already enabled
    wr(3'd7, 0, 1'b1);
    burst("R7 reload by control", 1600, 0, 0);

    // R5 request during a burst is ignored
    burst("R5 busy burst", 1608, 3, 0);
    idle_check("R5 busy request ignored", 4);
    burst("R4 after busy", 1616, 0, 0);

    // R11 start write colliding with exhaustion: set wins, reload uses old start
    wr(3'd4, 50, 1'b1);
    wr(3'd5, 50, 1'b1);
    wr(3'd6, 0, 1'b1);
    wr(3'd4, 50, 1'b1);
    check("R11 cleared before race", snd_irq, 0);
    burst("R11 race burst", 800, 1, 60);
    check("R11 set wins over clear", snd_irq, 1);
    burst("R9 reload used previous start", 800, 0, 0);
    wr(3'd4, 60, 1'b1);
    check("R11 later start write clears", snd_irq, 0);

    // R10 exhaustion after disabling mid-burst
    wr(3'd4, 70, 1'b1);
    wr(3'd5, 70, 1'b1);
    wr(3'd6, 0, 1'b1);
    wr(3'd4, 70, 1'b1);
    burst("R10 disabling burst", 1120, 2, 0);
    check("R10 clear pulse", chan_clear, 1);
    check("R8 irq with clear", snd_irq, 1);
    @(negedge clk);
    check("R10 clear pulse ends", chan_clear, 0);
    snd_req = 1'b1;
    idle_check("R5 ignored after disable", 5);
    snd_req = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule